// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block is a clocked front end for an asynchronous static RAM of 16-bit words with a separate strobe for each byte lane. The user side offers a single request: a read/write select, a word address, write data and a byte-enable mask. The request is taken when `ready_o` is high. The controller then sequences the active-low memory controls through an address setup phase, an access (read) or write-pulse phase, a hold phase and a recovery phase. Every phase is counted in clock cycles.

Reads return the full word in the cycle after the last access cycle, marked by a one-cycle `rvalid_o`, with disabled lanes forced to zero. Writes drive the data bus only inside the write pulse, and output enable stays high for the whole write. A request with an empty byte-enable mask still walks through every phase, but no memory control is ever pulled low. The bidirectional bus is split into an input, an output and a drive-enable, for an I/O cell at the chip edge.

Top module: `asram_port`

## Requirements
- R1: After reset, chip enable, write enable, output enable and both byte strobes are high, the bus drive-enable is low, `ready_o` is high and `rvalid_o` is low.
- R2: A request is accepted on a clock edge where `req_i` and `ready_o` are both high. `ready_o` is then low for exactly S+A+H+C cycles, where S, H and C are the setup, hold and recovery counts and A is the read access count (RD) or the write pulse count (WR). `ready_o` is high in the next cycle, and a request presented in that cycle is accepted at once.
- R3: `mem_addr_o` carries the request address from the first cycle after acceptance. It changes only between two cycles in which chip enable, write enable and every byte strobe are high.
- R4: For a read with a non-zero mask, chip enable and output enable are low and write enable is high for exactly RD cycles, starting in cycle S+1 after acceptance. The strobe of lane i is low in those cycles exactly when mask bit i is 1. Mask bit 0 selects bits [7:0] and bit 1 selects bits [15:8].
- R5: `rvalid_o` is high for one cycle only, in cycle S+RD+1 after a read is accepted. In that cycle, a lane whose mask bit is 0 reads as zero in `rdata_o`.
- R6: For a write with a non-zero mask, chip enable and write enable are low for exactly WR cycles from cycle S+1, output enable stays high, and the lane strobes follow the mask. Only enabled lanes of the stored word change.
- R7: During a write the bus drive-enable is high from cycle S+2 to cycle S+WR+1, which is from the cycle after write enable falls to the cycle after it rises. While it is high, `mem_dq_o` equals the write data, and it is never high while output enable is low.
- R8: With a mask of zero, no memory control goes low, the bus is not driven, the stored word does not change, the phase timing of R2 still holds, and a read returns zero with its `rvalid_o` pulse.
- R9: Read data is sampled at the end of the RD-th cycle of stable read enables. A full-mask read returns the last word written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| be_i | input | DATA_W/8 | Byte-enable mask, bit i selects lane i |
| ready_o | output | 1 | Controller idle, request can be accepted |
| rdata_o | output | DATA_W | Read data, disabled lanes zero |
| rvalid_o | output | 1 | One-cycle read data valid |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_bs_no | output | DATA_W/8 | Byte lane strobes, active low |
| mem_dq_o | output | DATA_W | Data toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | DATA_W | Data from the memory |

## Verification
Cycles are counted from the edge that accepts a request. Setup takes cycles 1 to S, and the access or write pulse takes the next RD or WR cycles. The bus drive-enable lags write enable by one cycle. `rvalid_o` and `rdata_o` are due in cycle S+RD+1, and `ready_o` returns in cycle S+A+H+C+1. The bench samples every memory control and handshake output at the falling edge of each of those cycles and compares it with a pattern computed from the cycle number, the operation and the mask. A bench memory model returns corrupt data for reads sampled before RD cycles of stable enables. The model commits a write only after a full pulse with the bus driven, and it counts address changes made while any strobe is low.

// File: rtl/asram_pkg.sv
package asram_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD,
    ST_RECOVER
  } st_e;
endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_TIMER_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && $past(!load_i) && $past(cnt_q) == '0) |-> cnt_q == '0); // R2
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int RD_CYC    = 6,
  parameter int WR_CYC    = 5,
  parameter int HOLD_CYC  = 1,
  parameter int REC_CYC   = 1,
  parameter int NB        = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [NB-1:0] be_i,
  output logic          ready_o,
  output logic          accept_o,
  output st_e           st_d_o,
  output logic          we_q_o,
  output logic [NB-1:0] be_q_o,
  output logic          capture_o
);
  localparam int M1   = (SETUP_CYC > RD_CYC) ? SETUP_CYC : RD_CYC;
  localparam int M2   = (WR_CYC > HOLD_CYC) ? WR_CYC : HOLD_CYC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > REC_CYC) ? M3 : REC_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  st_e           st_q, st_d;
  logic          we_q;
  logic [NB-1:0] be_q;
  logic          done;
  logic [CW-1:0] load_val;

  assign ready_o  = (st_q == ST_IDLE);
  assign accept_o = req_i && ready_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (accept_o) st_d = ST_SETUP;
      ST_SETUP:   if (done)     st_d = ST_ACCESS;
      ST_ACCESS:  if (done)     st_d = ST_HOLD;
      ST_HOLD:    if (done)     st_d = ST_RECOVER;
      ST_RECOVER: if (done)     st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_d)
      ST_SETUP:   load_val = CW'(SETUP_CYC - 1);
      ST_ACCESS:  load_val = we_q ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
      ST_HOLD:    load_val = CW'(HOLD_CYC - 1);
      ST_RECOVER: load_val = CW'(REC_CYC - 1);
      default:    load_val = '0;
    endcase
  end

  asram_timer #(.CW(CW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (st_d != st_q),
    .val_i  (load_val),
    .done_o (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      we_q <= 1'b0;
      be_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept_o) begin
        we_q <= we_i;
        be_q <= be_i;
      end
    end
  end

  assign st_d_o    = st_d;
  assign we_q_o    = we_q;
  assign be_q_o    = be_q;
  assign capture_o = (st_q == ST_ACCESS) && done && !we_q;

  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !ready_o); // R2
  AST_ACCESS_AFTER_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACCESS && $past(st_q) != ST_ACCESS) |-> $past(st_q) == ST_SETUP); // R3
  AST_REQ_LATCHED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> ($stable(we_q) && $stable(be_q))); // R6
endmodule

// File: rtl/asram_lane.sv
module asram_lane
  import asram_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [LANE_W-1:0] wbyte_i,
  input  logic              en_i,
  input  logic              act_d_i,
  input  logic              cap_i,
  input  logic [LANE_W-1:0] dq_i,
  output logic              bs_n_o,
  output logic [LANE_W-1:0] wbyte_o,
  output logic [LANE_W-1:0] rbyte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bs_n_o  <= 1'b1;
      wbyte_o <= '0;
      rbyte_o <= '0;
    end else begin
      bs_n_o <= !(act_d_i && en_i);
      if (accept_i) wbyte_o <= wbyte_i;
      if (cap_i)    rbyte_o <= en_i ? dq_i : '0;
    end
  end

  AST_LANE_STROBE_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bs_n_o |-> en_i); // R8
  AST_LANE_MASKED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cap_i) && !$past(en_i)) |-> rbyte_o == '0); // R5
endmodule

// File: rtl/asram_port.sv
module asram_port
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 1,
  parameter int RD_CYC    = 6,
  parameter int WR_CYC    = 5,
  parameter int HOLD_CYC  = 1,
  parameter int REC_CYC   = 1,
  localparam int NB       = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NB-1:0]     be_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [NB-1:0]     mem_bs_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  logic          accept, we_q, capture, act_d, any_be;
  logic [NB-1:0] be_q;
  st_e           st_d;

  asram_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .RD_CYC    (RD_CYC),
    .WR_CYC    (WR_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .REC_CYC   (REC_CYC),
    .NB        (NB)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .be_i      (be_i),
    .ready_o   (ready_o),
    .accept_o  (accept),
    .st_d_o    (st_d),
    .we_q_o    (we_q),
    .be_q_o    (be_q),
    .capture_o (capture)
  );

  assign act_d  = (st_d == ST_ACCESS);
  assign any_be = |be_q;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    asram_lane i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .accept_i (accept),
      .wbyte_i  (wdata_i[i*LANE_W +: LANE_W]),
      .en_i     (be_q[i]),
      .act_d_i  (act_d),
      .cap_i    (capture),
      .dq_i     (mem_dq_i[i*LANE_W +: LANE_W]),
      .bs_n_o   (mem_bs_no[i]),
      .wbyte_o  (mem_dq_o[i*LANE_W +: LANE_W]),
      .rbyte_o  (rdata_o[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o  <= '0;
      mem_ce_no   <= 1'b1;
      mem_we_no   <= 1'b1;
      mem_oe_no   <= 1'b1;
      mem_dq_oe_o <= 1'b0;
      rvalid_o    <= 1'b0;
    end else begin
      if (accept) mem_addr_o <= addr_i;
      mem_ce_no   <= !(act_d && any_be);
      mem_we_no   <= !(act_d && any_be && we_q);
      mem_oe_no   <= !(act_d && any_be && !we_q);
      // drive one cycle late on both edges of the write pulse
      mem_dq_oe_o <= !mem_we_no;
      rvalid_o    <= capture;
    end
  end

  AST_ADDR_MOVES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> (mem_ce_no && mem_we_no && (&mem_bs_no) &&
      $past(mem_ce_no) && $past(mem_we_no) && $past(&mem_bs_no))); // R3
  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_oe_no && !mem_ce_no)); // R6
  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no); // R7
  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |=> mem_dq_oe_o); // R7
  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R5
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&mem_bs_no) |-> !mem_ce_no); // R4
endmodule

// File: tb/test_asram_port.sv
module test_asram_port;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int S  = 1;
  localparam int RD = 6;
  localparam int WR = 5;
  localparam int H  = 1;
  localparam int RC = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0]    be = '0;
  logic          ready, rvalid, ce_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rdata, dq_o, dq_i;
  logic [AW-1:0] maddr;
  logic [1:0]    bs_n;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  asram_port #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .RD_CYC(RD),
    .WR_CYC(WR), .HOLD_CYC(H), .REC_CYC(RC)
  ) i_asram_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready), .rdata_o(rdata),
    .rvalid_o(rvalid), .mem_addr_o(maddr), .mem_ce_no(ce_n),
    .mem_we_no(we_n), .mem_oe_no(oe_n), .mem_bs_no(bs_n), .mem_dq_o(dq_o),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // memory model
  logic [DW-1:0] mem [1<<AW];
  int            rd_age = 0, wr_age = 0, viol = 0;
  logic [DW-1:0] wr_lat = '0;
  logic [1:0]    wr_bs = 2'b11;
  logic          wr_drv = 1'b0;
  logic [AW-1:0] addr_prev = '0;
  logic          prev_low = 1'b0;
  logic          rd_act;

  assign rd_act = !ce_n && !oe_n && we_n;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      if (rd_act && !bs_n[i])
        dq_i[i*8 +: 8] = (rd_age >= RD - 1) ? mem[maddr][i*8 +: 8] : 8'hEE;
      else
        dq_i[i*8 +: 8] = 8'h5A;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      rd_age <= rd_act ? rd_age + 1 : 0;
      if (!ce_n && !we_n) begin
        wr_age <= wr_age + 1;
        wr_lat <= dq_o;
        wr_bs  <= bs_n;
        wr_drv <= dq_oe;
      end else begin
        if (wr_age >= WR && wr_drv) begin
          for (int i = 0; i < 2; i++)
            if (!wr_bs[i]) mem[maddr][i*8 +: 8] <= wr_lat[i*8 +: 8];
        end
        wr_age <= 0;
      end
      if (maddr != addr_prev && (prev_low || !ce_n || !we_n || bs_n != 2'b11))
        viol <= viol + 1;
      if ((!we_n && !oe_n) || (dq_oe && !oe_n)) viol <= viol + 1;
      addr_prev <= maddr;
      prev_low  <= !ce_n || !we_n || bs_n != 2'b11;
    end
  end

  logic [DW-1:0] exp_mem [1<<AW];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction

  // starts and ends at a falling edge with ready high
  task automatic run_op(input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [1:0] b);
    int total;
    int alen;
    logic acc, anyb, e_ce, e_we, e_oe, e_doe, e_rv;
    logic [1:0] e_bs;
    string tag;
    alen  = w ? WR : RD;
    total = S + alen + H + RC;
    anyb  = (b != 2'b00);
    req = 1'b1; we = w; addr = a; wdata = d; be = b;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int c = 1; c <= total; c++) begin
      acc   = (c > S) && (c <= S + alen);
      e_ce  = !(acc && anyb);
      e_we  = !(acc && anyb && w);
      e_oe  = !(acc && anyb && !w);
      e_bs  = (acc && anyb) ? ~b : 2'b11;
      e_doe = w && anyb && (c >= S + 2) && (c <= S + alen + 1);
      e_rv  = !w && (c == S + alen + 1);
      if (!anyb)             tag = "R8";
      else if (dq_oe !== e_doe) tag = "R7";
      else if (w)            tag = "R6";
      else                   tag = "R4";
      chk(tag, {26'd0, ce_n, we_n, oe_n, bs_n, dq_oe},
               {26'd0, e_ce, e_we, e_oe, e_bs, e_doe});
      chk("R5", {31'd0, rvalid}, {31'd0, e_rv});
      chk("R2", {31'd0, ready}, 32'd0);
      if (c == 1) chk("R3", {28'd0, maddr}, {28'd0, a});
      if (e_doe) chk("R7", {16'd0, dq_o}, {16'd0, d});
      if (e_rv) begin
        if (!anyb)            tag = "R8";
        else if (b == 2'b11)  tag = "R9";
        else                  tag = "R5";
        chk(tag, {16'd0, rdata}, {16'd0, exp_mem[a] & lane_mask(b)});
      end
      @(negedge clk);
    end
    chk("R2", {31'd0, ready}, 32'd1);
    if (w) exp_mem[a] = (exp_mem[a] & ~lane_mask(b)) | (d & lane_mask(b));
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {27'd0, ce_n, we_n, oe_n, bs_n}, {27'd0, 5'b11111});
    chk("R1", {29'd0, dq_oe, ready, rvalid}, {29'd0, 3'b010});

    for (int a = 0; a < (1 << AW); a++) begin
      exp_mem[a] = 16'h0;
      run_op(1'b1, AW'(a), 16'((a * 16'h1357) ^ 16'hA5C3), 2'b11);
    end
    for (int a = 0; a < (1 << AW); a++) begin
      for (int b = 0; b < 4; b++) begin
        run_op(1'b1, AW'(a), 16'((a * 16'h0F1D) ^ (b * 16'h3C81) ^ 16'h7E24), 2'(b));
        for (int r = 0; r < 4; r++) run_op(1'b0, AW'(a), 16'h0, 2'(r));
      end
    end
    chk("R3", viol, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule